// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block exposes a 256-entry byte-wide configuration space through two byte addresses. Address 0 is a pointer: writing it selects which configuration byte the second address reaches, and reading it returns that pointer. Address 1 is the window: reads return the selected byte, writes update it unless that byte is read-only. Only the high window of the space (indices 0xE0 to 0xFF) holds storage. Everything below reads as zero and cannot be written. Several bytes in that window come out of reset holding fixed identification and base-address values.

The whole port is switched on and off by one bit of a control byte that the host writes on a separate strobe. While the port is off, reads return 0xFF and writes change nothing, not even the pointer. Read data appears one cycle after the request with a valid strobe. A writable byte that has no known function also raises a one-cycle flag when it is written, so that software touching unused bytes can be spotted.

Top module: `cfgport_top`

## Requirements
- R1: After reset the pointer is 0 and the port is disabled, so the first read returns 0xFF. `rd_valid` and `unimpl_pulse` are low.
- R2: The port enable is bit 1 of the last byte written with `ctl_we`, and the other bits of that byte are ignored. An access in the same cycle as a control write is judged by the enable as it stood before that write.
- R3: While enabled, a write to address 0 (`acc_addr`=0) loads the pointer. A read from address 0 returns the pointer.
- R4: Every read request produces `rd_valid` high for exactly the following cycle, with the result on `rd_data` in that cycle.
- R5: A read from address 1 while the pointer is 0 returns 0x00.
- R6: A write to address 1 has no effect when the pointer is at one of these indices: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R7: A write to address 1 at any other index stores the byte, and later reads at that index return it.
- R8: Reset values are 0x3C at 0xE0, 0x03 at 0xE2, 0xFC at 0xE3, 0xDE at 0xE6, 0xFE at 0xE7 and 0xBE at 0xE8. All other bytes reset to 0x00.
- R9: While disabled, every read returns 0xFF, and writes to either address change no state.
- R10: An enabled write to address 1 at a writable index outside 0xE0–0xE8 raises `unimpl_pulse` for exactly the next cycle. Other writes leave it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Strobe that loads the control byte |
| ctl_byte | input | 8 | Control byte; bit 1 enables the port |
| acc_valid | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = pointer, 1 = data window |
| acc_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| unimpl_pulse | output | 1 | Write hit an unassigned writable byte |

## Verification
The two functions that can meet in one cycle are a control-byte write that turns the port off or on and a pointer or data access issued on the same edge. The bench drives both in a single cycle. It expects the access to be served under the old enable, and a following read to show the new one. It also sweeps every index with a write and a readback, to judge protection and storage at each byte.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  // Data-port writes are dropped at these indices.
  function automatic logic idx_is_ro(input logic [7:0] i);
    return (i <= 8'hDF) ||
           (i == 8'hE4) || (i == 8'hE5) ||
           (i >= 8'hE9 && i <= 8'hED) ||
           (i == 8'hF3) || (i == 8'hF5) || (i == 8'hF7) ||
           (i >= 8'hF9 && i <= 8'hFB) ||
           (i >= 8'hFD);
  endfunction

  // Writable but without an assigned function.
  function automatic logic idx_is_unimpl(input logic [7:0] i);
    return !idx_is_ro(i) && !(i >= 8'hE0 && i <= 8'hE8);
  endfunction

  function automatic logic [7:0] idx_reset_val(input logic [7:0] i);
    case (i)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgport_enable.sv
module cfgport_enable #(
  parameter int DW     = 8,
  parameter int EN_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [DW-1:0] ctl_byte,
  output logic          en_q
);
  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (ctl_we) en_q <= ctl_byte[EN_BIT];
  end
endmodule

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
  parameter int IDX_W = 8
) (
  input  logic             en,
  input  logic             acc_valid,
  input  logic             acc_wr,
  input  logic             acc_addr,
  input  logic [IDX_W-1:0] idx,
  output logic             ptr_we,
  output logic             dat_we,
  output logic             unimpl_hit
);
  import cfgport_pkg::*;
  logic wr_ok;
  always_comb begin
    wr_ok      = en && acc_valid && acc_wr;
    ptr_we     = wr_ok && !acc_addr;
    dat_we     = wr_ok && acc_addr && !idx_is_ro(idx);
    unimpl_hit = wr_ok && acc_addr && idx_is_unimpl(idx);
  end
endmodule

// File: rtl/cfgport_window.sv
module cfgport_window #(
  parameter int          IDX_W    = 8,
  parameter int          DW       = 8,
  parameter int          WIN_LOG2 = 5,
  parameter logic [7:0]  WIN_BASE = 8'hE0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  import cfgport_pkg::*;
  localparam int WIN_N = 1 << WIN_LOG2;

  logic [DW-1:0]    slot [WIN_N];
  logic [IDX_W-1:0] woff, roff;
  logic             w_in, r_in;

  assign woff = waddr - IDX_W'(WIN_BASE);
  assign roff = raddr - IDX_W'(WIN_BASE);
  assign w_in = (waddr >= IDX_W'(WIN_BASE)) && (woff < IDX_W'(WIN_N));
  assign r_in = (raddr >= IDX_W'(WIN_BASE)) && (roff < IDX_W'(WIN_N));

  for (genvar g = 0; g < WIN_N; g++) begin : g_slot
    localparam logic [7:0] GIDX = 8'(WIN_BASE + g);
    if (idx_is_ro(GIDX)) begin : g_const
      assign slot[g] = DW'(idx_reset_val(GIDX));
    end else begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= DW'(idx_reset_val(GIDX));
        else if (we && w_in && woff[WIN_LOG2-1:0] == WIN_LOG2'(g)) q <= wdata;
      end
      assign slot[g] = q;
    end
  end

  assign rdata = r_in ? slot[roff[WIN_LOG2-1:0]] : '0;
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top #(
  parameter int         DW       = 8,
  parameter int         IDX_W    = 8,
  parameter int         EN_BIT   = 1,
  parameter int         WIN_LOG2 = 5,
  parameter logic [7:0] WIN_BASE = 8'hE0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_byte,
  input  logic          acc_valid,
  input  logic          acc_wr,
  input  logic          acc_addr,
  input  logic [7:0]    acc_wdata,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          unimpl_pulse
);
  localparam logic [DW-1:0] IDLE_RD = '1;

  logic             port_en;
  logic [IDX_W-1:0] idx_q;
  logic             ptr_we, dat_we, unimpl_hit;
  logic [DW-1:0]    win_rdata;
  logic [DW-1:0]    rd_next;

  cfgport_enable #(.DW(DW), .EN_BIT(EN_BIT)) u_en (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_byte(ctl_byte), .en_q(port_en));

  cfgport_decode #(.IDX_W(IDX_W)) u_dec (
    .en(port_en), .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .idx(idx_q), .ptr_we(ptr_we), .dat_we(dat_we), .unimpl_hit(unimpl_hit));

  cfgport_window #(.IDX_W(IDX_W), .DW(DW), .WIN_LOG2(WIN_LOG2),
                   .WIN_BASE(WIN_BASE)) u_win (
    .clk(clk), .rst(rst), .we(dat_we), .waddr(idx_q), .wdata(acc_wdata),
    .raddr(idx_q), .rdata(win_rdata));

  always_comb begin
    if (!port_en)          rd_next = IDLE_RD;
    else if (!acc_addr)    rd_next = DW'(idx_q);
    else if (idx_q == '0)  rd_next = '0;
    else                   rd_next = win_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q        <= '0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      unimpl_pulse <= 1'b0;
    end else begin
      rd_valid     <= acc_valid && !acc_wr;
      unimpl_pulse <= unimpl_hit;
      if (acc_valid && !acc_wr) rd_data <= rd_next;
      if (ptr_we) idx_q <= IDX_W'(acc_wdata);
    end
  end
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_wr,
  input logic       acc_addr,
  input logic [7:0] acc_wdata,
  input logic       en,
  input logic [7:0] idx,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       unimpl
);
  assert_rd_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wr) |=> rd_valid);
  assert_rd_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_wr) |=> !rd_valid);
  assert_dis_read_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wr && !en) |=> rd_data == 8'hFF);
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_wr && !acc_addr && en) |=> $stable(idx));
  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_wr && !acc_addr && en) |=> idx == $past(acc_wdata));
  assert_idx0_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wr && acc_addr && en && idx == 8'h00) |=> rd_data == 8'h00);
  assert_flag_src_R10: assert property (@(posedge clk) disable iff (rst)
    unimpl |-> $past(acc_valid && acc_wr && acc_addr && en));
endmodule

bind cfgport_top cfgport_chk u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .en(port_en), .idx(idx_q),
  .rd_valid(rd_valid), .rd_data(rd_data), .unimpl(unimpl_pulse));

// File: tb/cfgport_top_tb.sv
module cfgport_top_tb;
  logic clk = 0, rst = 1;
  logic ctl_we = 0, acc_valid = 0, acc_wr = 0, acc_addr = 0;
  logic [7:0] ctl_byte = 0, acc_wdata = 0;
  logic rd_valid, unimpl_pulse;
  logic [7:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_idx;
  logic       m_en;

  logic [7:0] q_exp [$];
  string      q_tag [$];

  always #10 clk = ~clk;

  cfgport_top u_dut (.clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
    .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .unimpl_pulse(unimpl_pulse));

  function automatic bit wr_ok(input logic [7:0] i);
    if (i < 8'hE0) return 0;
    case (i)
      8'hE4, 8'hE5, 8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED, 8'hF3, 8'hF5, 8'hF7,
      8'hF9, 8'hFA, 8'hFB, 8'hFD, 8'hFE, 8'hFF: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic a);
    if (!m_en) return 8'hFF;
    if (!a) return m_idx;
    if (m_idx == 0) return 8'h00;
    return m_mem[m_idx];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_mem[8'hE0] = 8'h3C; m_mem[8'hE2] = 8'h03; m_mem[8'hE3] = 8'hFC;
    m_mem[8'hE6] = 8'hDE; m_mem[8'hE7] = 8'hFE; m_mem[8'hE8] = 8'hBE;
    m_idx = 0; m_en = 0;
  endtask

  task automatic do_ctl(input logic [7:0] b);
    @(negedge clk); ctl_we = 1; ctl_byte = b;
    @(negedge clk); ctl_we = 0; m_en = b[1];
  endtask

  task automatic do_rd(input logic a, input string tag);
    @(negedge clk);
    acc_valid = 1; acc_wr = 0; acc_addr = a;
    q_exp.push_back(m_read(a)); q_tag.push_back(tag);
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d, input string tag);
    bit exp_flag;
    @(negedge clk);
    acc_valid = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    exp_flag = m_en && a && wr_ok(m_idx) && !(m_idx >= 8'hE0 && m_idx <= 8'hE8);
    if (m_en) begin
      if (!a) m_idx = d;
      else if (wr_ok(m_idx)) m_mem[m_idx] = d;
    end
    @(negedge clk);
    check(unimpl_pulse == exp_flag, {tag, " R10 flag"}, unimpl_pulse, exp_flag);
    acc_valid = 0; acc_wr = 0;
  endtask

  // control write and read issued in the same cycle (R2)
  task automatic do_ctl_rd(input logic [7:0] b, input logic a);
    @(negedge clk);
    ctl_we = 1; ctl_byte = b; acc_valid = 1; acc_wr = 0; acc_addr = a;
    q_exp.push_back(m_read(a)); q_tag.push_back("R2 same-cycle");
    @(negedge clk);
    ctl_we = 0; acc_valid = 0; m_en = b[1];
  endtask

  // scoreboard monitor (R4 data path)
  always @(negedge clk) begin
    if (!rst && rd_valid && !done) begin
      if (q_exp.size() == 0) check(0, "R4 unexpected rd_valid", 1, 0);
      else begin
        logic [7:0] e; string t;
        e = q_exp.pop_front(); t = q_tag.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
    check(unimpl_pulse == 0, "R1 flag after reset", unimpl_pulse, 0);
    do_rd(0, "R1 disabled first read");
    do_rd(1, "R9 disabled data read");
    do_wr(0, 8'hE0, "R9 disabled ptr write");
    do_wr(1, 8'h11, "R9 disabled data write");
    do_ctl(8'hFD);
    do_rd(0, "R2 bit1 clear keeps port off");
    do_ctl(8'h02);
    do_rd(0, "R9 ptr untouched while off / R1 reset ptr");
    do_rd(1, "R5 index 0 reads zero");
    foreach (m_mem[k]) if (k >= 8'hE0 && k <= 8'hE8) begin
      do_wr(0, 8'(k), "R3 ptr load");
      do_rd(0, "R3 ptr readback");
      do_rd(1, "R8 reset value");
    end
    do_wr(0, 8'hE0, "R3 ptr");
    do_wr(1, 8'h55, "R7 write E0");
    do_rd(1, "R7 readback E0");
    do_wr(0, 8'hE4, "R3 ptr");
    do_wr(1, 8'hAA, "R6 write E4");
    do_rd(1, "R6 E4 unchanged");
    do_wr(0, 8'h00, "R3 ptr");
    do_wr(1, 8'h77, "R6 write idx0");
    do_rd(0, "R6 idx0 write keeps ptr");
    do_rd(1, "R5 idx0 zero");
    do_wr(0, 8'hEE, "R3 ptr");
    do_wr(1, 8'h5A, "R10 unimpl EE");
    do_rd(1, "R7 readback EE");
    do_wr(0, 8'hF3, "R3 ptr");
    do_wr(1, 8'h66, "R6 write F3 no flag");
    do_rd(1, "R6 F3 unchanged");
    do_ctl_rd(8'h00, 1);
    do_rd(1, "R9 off after same-cycle write");
    do_wr(1, 8'h99, "R9 write while off");
    do_ctl_rd(8'h02, 0);
    do_rd(1, "R9 F3 still unchanged");
    for (int i = 0; i < 256; i++) begin
      do_wr(0, 8'(i), "R3 sweep ptr");
      do_wr(1, 8'(i) ^ 8'hA5, "R6 R7 sweep write");
      do_rd(1, "R6 R7 sweep readback");
    end
    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R4 all reads answered", q_exp.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule